// File: doc/BRIEF.md
# Code-Density Delay Calibrator

This block calibrates a tapped delay line with a statistical code-density method. After power-up, and again when a restart command arrives while it is idle, it takes over the line's input. It steers pulses from a free-running on-chip ring oscillator into the line in place of the user signal. An external encoder turns each resulting capture into a raw tap index. The block counts those indices in a histogram until a fixed total of 2^HIT_LOG2 hits has arrived.

Taps that are wider in time collect proportionally more hits. The block sweeps the histogram once and keeps a running sum. For every tap it writes the time of that tap's bin centre into a lookup table. The timestamp path can read the table once calibration is complete. As the last step, the block counts rising edges of a compensation ring oscillator over a fixed window of system clock cycles. It holds that count in an output register.

The histogram and the lookup table are inferred RAMs inside the block. The ring oscillators and the tap encoder are outside it.

Top module: `tdc_delay_cal`

## Requirements
- R1: After reset `busy_o` is high. Calibration starts without any command. `busy_o` stays high through clearing, accumulation, integration and the whole frequency window, which lasts WIN_CYCLES cycles. It goes low only when the sequence is complete.
- R2: `line_o` equals `cal_osc_i` while `busy_o` is high and equals `user_sig_i` while it is low.
- R3: At the start of every calibration run, every histogram count is cleared to zero. No count carries over from an earlier run.
- R4: During accumulation, each cycle with `hit_valid_i` high adds one hit to tap `hit_tap_i`. Exactly 2^HIT_LOG2 hits are accepted. Hits after the last accepted one, and hits outside accumulation, are ignored.
- R5: A tap count saturates at 2^CNT_W-1 and does not wrap. Hits that arrive on a saturated tap still count toward the 2^HIT_LOG2 total.
- R6: Lookup entry i equals 2*(c0+...+c(i-1)) + ci, where cj is the stored count of tap j. This is the bin centre in units of one clock period divided by 2^(HIT_LOG2+1).
- R7: `freq_count_o` is zero after reset. At the end of each run it takes the number of rising edges of `comp_osc_i` seen during the WIN_CYCLES window, which is within one of the true count. It holds that value until the next run ends.
- R8: A read with `lut_rd_en_i` high while calibration is complete returns the entry at `lut_rd_addr_i` on `lut_rd_data_o` one cycle later, with `lut_rd_valid_o` high. A read at any other time gives `lut_rd_valid_o` low and `lut_rd_data_o` zero.
- R9: A one-cycle `cal_start_i` while calibration is complete raises `busy_o` on the next cycle and begins a new run. `cal_start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start_i | input | 1 | Restart command, one cycle |
| user_sig_i | input | 1 | Signal to be timed in normal operation |
| cal_osc_i | input | 1 | Random-phase pulses from the calibration ring oscillator |
| line_o | output | 1 | Drive of the delay line input |
| hit_valid_i | input | 1 | Encoder has a new tap index |
| hit_tap_i | input | $clog2(TAPS) | Raw tap index from the encoder |
| comp_osc_i | input | 1 | Compensation ring oscillator, asynchronous |
| lut_rd_en_i | input | 1 | Lookup read request |
| lut_rd_addr_i | input | $clog2(TAPS) | Lookup read address (tap index) |
| lut_rd_data_o | output | HIT_LOG2+2 | Bin-centre time of the addressed tap |
| lut_rd_valid_o | output | 1 | Read data valid |
| freq_count_o | output | FREQ_W | Compensation oscillator edge count per window |
| busy_o | output | 1 | Calibration in progress |

## Verification
A histogram count that is not cleared, is lost, or wraps instead of saturating corrupts the addressed lookup entry. Because each entry is a running sum, the same error also shifts every entry above that tap. A sweep of all entries in the next ready period therefore exposes it. A hit limit that is off by one, or a restart that is accepted while busy, changes the counts of specific taps. A miscounting window moves `freq_count_o` outside its one-count tolerance. A sequencer fault shows as `busy_o` dropping too early or too late, or as `line_o` following the wrong source on the very next sample.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_ACCUM,
      ST_INTEG,
      ST_FREQ,
      ST_READY
   } cal_state_t;
endpackage

// File: rtl/tdc_cal_hist.sv
module tdc_cal_hist #(
   parameter int TAPS  = 64,
   parameter int CNT_W = 13,
   localparam int TAP_W = $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic             acc_en,
   input  logic [TAP_W-1:0] idx,
   input  logic [TAP_W-1:0] hit_tap,
   output logic [CNT_W-1:0] rd_data
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [CNT_W-1:0] bin_mem [TAPS];
   logic [CNT_W-1:0] cur;

   assign cur     = bin_mem[hit_tap];
   assign rd_data = bin_mem[idx];

   always_ff @(posedge clk) begin
      if (clr_en)
         bin_mem[idx] <= '0;
      else if (acc_en && cur != CMAX)
         bin_mem[hit_tap] <= cur + 1'b1;
   end

   // R5
   bin_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !clr_en && cur == CMAX) |=> bin_mem[$past(hit_tap)] == CMAX);

   // R4
   bin_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !clr_en && cur != CMAX) |=> bin_mem[$past(hit_tap)] == CNT_W'($past(cur) + 1'b1));
endmodule

// File: rtl/tdc_cal_lut.sv
module tdc_cal_lut #(
   parameter int TAPS     = 64,
   parameter int CNT_W    = 13,
   parameter int HIT_LOG2 = 12,
   localparam int TAP_W = $clog2(TAPS),
   localparam int LUT_W = HIT_LOG2 + 2,
   localparam int ACC_W = HIT_LOG2 + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_clr,
   input  logic             integ_en,
   input  logic [TAP_W-1:0] idx,
   input  logic [CNT_W-1:0] cnt_in,
   input  logic             rd_en,
   input  logic [TAP_W-1:0] rd_addr,
   output logic [LUT_W-1:0] rd_data,
   output logic             rd_valid
);
   logic [LUT_W-1:0] lut_mem [TAPS];
   logic [ACC_W-1:0] acc_q;
   logic [LUT_W-1:0] wdata;

   assign wdata = {acc_q, 1'b0} + LUT_W'(cnt_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (acc_clr)
         acc_q <= '0;
      else if (integ_en)
         acc_q <= acc_q + ACC_W'(cnt_in);
   end

   always_ff @(posedge clk) begin
      if (integ_en)
         lut_mem[idx] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         rd_data  <= rd_en ? lut_mem[rd_addr] : '0;
      end
   end

   // R6
   lut_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (integ_en && idx != '0) |-> wdata >= lut_mem[idx - 1'b1]);
endmodule

// File: rtl/tdc_cal_freq.sv
module tdc_cal_freq #(
   parameter int WIN_CYCLES  = 4096,
   parameter int FREQ_W      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int WIN_W = $clog2(WIN_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_i,
   input  logic              en,
   output logic              done,
   output logic [FREQ_W-1:0] freq_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;
   logic [WIN_W-1:0]       win_q;
   logic [FREQ_W-1:0]      cnt_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= osc_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign done = en && (win_q == WIN_W'(WIN_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         cnt_q  <= '0;
         freq_o <= '0;
      end else if (!en) begin
         win_q <= '0;
         cnt_q <= '0;
      end else begin
         win_q <= win_q + 1'b1;
         cnt_q <= cnt_q + FREQ_W'(rise);
         if (done)
            freq_o <= cnt_q + FREQ_W'(rise);
      end
   end

   // R7
   freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(freq_o));

   // R7
   freq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> freq_o <= FREQ_W'(WIN_CYCLES));
endmodule

// File: rtl/tdc_delay_cal.sv
module tdc_delay_cal
   import tdc_cal_pkg::*;
#(
   parameter int TAPS        = 64,
   parameter int HIT_LOG2    = 12,
   parameter int CNT_W       = 13,
   parameter int WIN_CYCLES  = 4096,
   parameter int FREQ_W      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int TAP_W = $clog2(TAPS),
   localparam int LUT_W = HIT_LOG2 + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_start_i,
   input  logic              user_sig_i,
   input  logic              cal_osc_i,
   output logic              line_o,
   input  logic              hit_valid_i,
   input  logic [TAP_W-1:0]  hit_tap_i,
   input  logic              comp_osc_i,
   input  logic              lut_rd_en_i,
   input  logic [TAP_W-1:0]  lut_rd_addr_i,
   output logic [LUT_W-1:0]  lut_rd_data_o,
   output logic              lut_rd_valid_o,
   output logic [FREQ_W-1:0] freq_count_o,
   output logic              busy_o
);
   localparam int TOT_W = HIT_LOG2 + 1;
   localparam int HITS  = 1 << HIT_LOG2;

   if (TAPS < 2 || (1 << TAP_W) != TAPS) begin : g_bad_taps
      $error("TAPS must be a power of two, at least 2");
   end
   if (CNT_W < 1 || CNT_W > HIT_LOG2 + 1) begin : g_bad_cnt
      $error("CNT_W must lie in 1..HIT_LOG2+1");
   end
   if (WIN_CYCLES < 2) begin : g_bad_win
      $error("WIN_CYCLES must be at least 2");
   end
   if (FREQ_W < $clog2(WIN_CYCLES + 1)) begin : g_bad_freq
      $error("FREQ_W too narrow for the window");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   cal_state_t       state;
   logic [TAP_W-1:0] idx_q;
   logic [TOT_W-1:0] hit_total;
   logic [CNT_W-1:0] bin_cnt;
   logic             idx_last;
   logic             acc_en;
   logic             freq_done;

   assign idx_last = (idx_q == TAP_W'(TAPS - 1));
   assign acc_en   = (state == ST_ACCUM) && hit_valid_i;
   assign busy_o   = (state != ST_READY);
   assign line_o   = busy_o ? cal_osc_i : user_sig_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx_q     <= '0;
         hit_total <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               idx_q <= '0;
               state <= ST_CLEAR;
            end
            ST_CLEAR: begin
               idx_q <= idx_q + 1'b1;
               if (idx_last) begin
                  hit_total <= '0;
                  state     <= ST_ACCUM;
               end
            end
            ST_ACCUM: begin
               if (hit_valid_i) begin
                  hit_total <= hit_total + 1'b1;
                  if (hit_total == TOT_W'(HITS - 1)) begin
                     idx_q <= '0;
                     state <= ST_INTEG;
                  end
               end
            end
            ST_INTEG: begin
               idx_q <= idx_q + 1'b1;
               if (idx_last) state <= ST_FREQ;
            end
            ST_FREQ: begin
               if (freq_done) state <= ST_READY;
            end
            ST_READY: begin
               if (cal_start_i) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   tdc_cal_hist #(
      .TAPS  (TAPS),
      .CNT_W (CNT_W)
   ) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_en  (state == ST_CLEAR),
      .acc_en  (acc_en),
      .idx     (idx_q),
      .hit_tap (hit_tap_i),
      .rd_data (bin_cnt)
   );

   tdc_cal_lut #(
      .TAPS     (TAPS),
      .CNT_W    (CNT_W),
      .HIT_LOG2 (HIT_LOG2)
   ) u_lut (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_clr  (state == ST_IDLE),
      .integ_en (state == ST_INTEG),
      .idx      (idx_q),
      .cnt_in   (bin_cnt),
      .rd_en    (lut_rd_en_i && state == ST_READY),
      .rd_addr  (lut_rd_addr_i),
      .rd_data  (lut_rd_data_o),
      .rd_valid (lut_rd_valid_o)
   );

   tdc_cal_freq #(
      .WIN_CYCLES  (WIN_CYCLES),
      .FREQ_W      (FREQ_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_freq (
      .clk    (clk),
      .rst_n  (rst_n),
      .osc_i  (comp_osc_i),
      .en     (state == ST_FREQ),
      .done   (freq_done),
      .freq_o (freq_count_o)
   );

   // R4
   hit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACCUM) |-> hit_total < TOT_W'(HITS));

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && cal_start_i) |=> busy_o);

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && state != ST_IDLE && cal_start_i) |=> state != ST_IDLE);
endmodule

// File: tb/tdc_delay_cal_tb.sv
module tdc_delay_cal_tb;
   localparam int TAPS = 8;
   localparam int K    = 6;
   localparam int CW   = 5;
   localparam int WIN  = 200;
   localparam int FW   = 16;
   localparam int TW   = $clog2(TAPS);
   localparam int LW   = K + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cal_start = 1'b0, user_sig = 1'b0, cal_osc = 1'b0;
   logic hit_valid = 1'b0, comp_osc = 1'b0, rd_en = 1'b0;
   logic [TW-1:0] hit_tap = '0, rd_addr = '0;
   logic line;
   logic [LW-1:0] rd_data;
   logic rd_valid, busy;
   logic [FW-1:0] freq;

   int n_chk = 0, n_bad = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;
   always #32 comp_osc = ~comp_osc;

   tdc_delay_cal #(
      .TAPS(TAPS), .HIT_LOG2(K), .CNT_W(CW), .WIN_CYCLES(WIN),
      .FREQ_W(FW), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cal_start_i(cal_start), .user_sig_i(user_sig),
      .cal_osc_i(cal_osc), .line_o(line), .hit_valid_i(hit_valid),
      .hit_tap_i(hit_tap), .comp_osc_i(comp_osc), .lut_rd_en_i(rd_en),
      .lut_rd_addr_i(rd_addr), .lut_rd_data_o(rd_data),
      .lut_rd_valid_o(rd_valid), .freq_count_o(freq), .busy_o(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic feed(input int tap, input int n);
      repeat (n) begin
         @(negedge clk);
         hit_valid = 1'b1;
         hit_tap   = TW'(tap);
      end
   endtask

   task automatic feed_stop();
      @(negedge clk);
      hit_valid = 1'b0;
   endtask

   task automatic wait_ready(output int cycles);
      cycles = 0;
      while (busy && cycles < 5000) begin
         @(negedge clk);
         cycles++;
      end
   endtask

   // R6 and R8: sweep the table against counts computed from the requirements
   task automatic check_lut(input int cnt[TAPS], input string tag);
      int sum = 0;
      for (int i = 0; i < TAPS; i++) begin
         int c = (cnt[i] > (1 << CW) - 1) ? (1 << CW) - 1 : cnt[i];
         int exp = 2 * sum + c;
         @(negedge clk);
         rd_en = 1'b1;
         rd_addr = TW'(i);
         @(negedge clk);
         rd_en = 1'b0;
         chk(rd_valid == 1'b1, "R8 valid", int'(rd_valid), 1);
         chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
         sum += c;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      chk(busy == 1'b1, "R1 busy after reset", int'(busy), 1);
      chk(rd_valid == 1'b0, "R8 valid after reset", int'(rd_valid), 0);
      chk(freq == '0, "R7 freq after reset", int'(freq), 0);
   endtask

   task automatic t_line_busy();
      cal_osc = 1'b1; user_sig = 1'b0; #1;
      chk(line == 1'b1, "R2 line follows osc", int'(line), 1);
      cal_osc = 1'b0; user_sig = 1'b1; #1;
      chk(line == 1'b0, "R2 line ignores user", int'(line), 0);
   endtask

   task automatic t_read_blocked();
      @(negedge clk);
      rd_en = 1'b1; rd_addr = TW'(2);
      @(negedge clk);
      rd_en = 1'b0;
      chk(rd_valid == 1'b0, "R8 blocked valid", int'(rd_valid), 0);
      chk(rd_data == '0, "R8 blocked data", int'(rd_data), 0);
   endtask

   task automatic t_run_a();
      int cnt[TAPS] = '{4, 8, 12, 0, 10, 6, 16, 8};
      int cyc;
      repeat (15) @(negedge clk);
      t_read_blocked();
      for (int i = 0; i < TAPS; i++) feed(i, cnt[i]);
      feed(3, 6);                       // R4: past the total, must be ignored
      feed_stop();
      repeat (WIN - 20) @(negedge clk);
      chk(busy == 1'b1, "R1 busy during window", int'(busy), 1);
      wait_ready(cyc);
      chk(busy == 1'b0, "R1 ready reached", int'(busy), 0);
      chk(freq >= 24 && freq <= 26, "R7 freq count", int'(freq), 25);
      user_sig = 1'b1; cal_osc = 1'b0; #1;
      chk(line == 1'b1, "R2 line follows user", int'(line), 1);
      user_sig = 1'b0; cal_osc = 1'b1; #1;
      chk(line == 1'b0, "R2 line ignores osc", int'(line), 0);
      cal_osc = 1'b0;
      check_lut(cnt, "R6/R4 lut run A");
   endtask

   task automatic t_run_b();
      int cnt[TAPS] = '{0, 24, 0, 0, 0, 40, 0, 0};
      int cyc;
      logic [FW-1:0] f_prev = freq;
      @(negedge clk);
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      chk(busy == 1'b1, "R9 restart raises busy", int'(busy), 1);
      chk(freq == f_prev, "R7 freq held", int'(freq), int'(f_prev));
      repeat (15) @(negedge clk);
      feed(1, 24);
      @(negedge clk);
      hit_valid = 1'b0;
      cal_start = 1'b1;                  // R9: busy, must be ignored
      @(negedge clk);
      cal_start = 1'b0;
      feed(5, 40);
      feed_stop();
      wait_ready(cyc);
      chk(busy == 1'b0, "R1 ready after run B", int'(busy), 0);
      check_lut(cnt, "R3/R5/R9 lut run B");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_line_busy();
      t_run_a();
      t_run_b();
      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule